// File: doc/BRIEF.md
# Four-Channel 14-Bit DAC Host Load Interface

This block is the digital front end of a four-channel, 14-bit digital-to-analog converter that is loaded from a parallel host bus. A host write selects one of four channels with a 3-bit channel address. The write is qualified by an active-low chip select and completes on the rising edge of an active-low write strobe. Each channel is double-buffered. The write lands in the channel's input register, and a separate DAC latch holds the code that the converter sees.

A format input picks how a write is applied. In word format, one write carries all 14 bits. In byte format, a value is built from two writes with the data right-justified on the bus. The byte-shift input low places bus bits [7:0] into register bits [7:0]. The byte-shift input high places bus bits [5:0] into register bits [13:8].

An active-low load control moves input registers into the latches. Held low, it makes every latch follow its input register, so each write reaches the output directly. Held high, it freezes the outputs, and its falling edge updates all four latches in the same cycle. An asynchronous active-low clear forces every input register and latch to mid-scale. The synchronous reset does the same, which gives a defined power-up state. All host strobes are brought into the system clock domain through a two-stage synchroniser.

Top module: `quad_dac_load_if`

## Requirements
- R1: While `rst_n` is sampled low on a clock edge, every channel of `dac_out` is mid-scale (14'h2000) after that edge.
- R2: In word format (`byte_fmt`=0), a write with `cs_n` low to channel address 0..3 loads all 14 bits of `data` into that channel only. Channel k occupies `dac_out[14k+13:14k]`.
- R3: In byte format (`byte_fmt`=1) with `byte_hi`=0, a write replaces register bits [7:0] with `data[7:0]` and leaves bits [13:8] unchanged.
- R4: In byte format with `byte_hi`=1, a write replaces register bits [13:8] with `data[5:0]`. Bus bits [13:6] and register bits [7:0] are unaffected.
- R5: A write to channel address 4, 5, 6 or 7 changes no input register and no output.
- R6: A write strobe pulse while `cs_n` is high changes no input register and no output.
- R7: A write is committed only at the rising edge of `wr_n`. Nothing changes while `wr_n` is held low, and bus changes after the commit have no effect.
- R8: While `ldac_n` is held high, writes update input registers but `dac_out` holds its value.
- R9: While `ldac_n` is low, each latch follows its input register. A falling edge of `ldac_n` copies all four input registers to `dac_out` in the same cycle.
- R10: `clr_n` low forces all four outputs to mid-scale without waiting for a clock edge. It also clears the input registers, so a later load still gives mid-scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, sets mid-scale |
| clr_n | input | 1 | Asynchronous active-low clear to mid-scale |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe, commits on rising edge |
| addr | input | 3 | Channel address, 0..3 valid |
| byte_fmt | input | 1 | 0 = word format, 1 = byte format |
| byte_hi | input | 1 | Byte format: 0 = low 8 bits, 1 = high 6 bits |
| data | input | 14 | Host data bus, right-justified |
| ldac_n | input | 1 | Active-low load control for the DAC latches |
| dac_out | output | 56 | Four 14-bit latch codes, channel k at bits [14k+13:14k] |

## Verification
The assertions assume that `clr_n` changes only at levels that last at least one full clock period. They also assume that the address, data, format and chip-select lines are held steady for at least three clock cycles after `wr_n` rises, so that the synchronised strobe and its data arrive together. The stimulus meets both assumptions. Every input is changed on the falling clock edge, every write holds the bus for three cycles after the strobe rises, and every clear pulse lasts several cycles. The asynchronous effect of `clr_n` is still observed partway through a cycle, before any rising edge.

// File: rtl/qdac_pkg.sv
// Shared constants and types for the four-channel DAC host load interface.
// Assumes a 14-bit code split into an 8-bit low part and a 6-bit high part.
package qdac_pkg;
    localparam int DAC_W       = 14;
    localparam int NUM_CH      = 4;
    localparam int ADDR_W      = 3;
    localparam int LOW_W       = 8;
    localparam int SYNC_STAGES = 2;

    // Write format selected by the byte_fmt input.
    typedef enum logic {
        FMT_WORD  = 1'b0,
        FMT_BYTES = 1'b1
    } load_fmt_e;
endpackage

// File: rtl/qdac_bus_sync.sv
// Brings the asynchronous host bus into the clock domain through STAGES
// flops and flags the rising edge of the synchronised write strobe.
// Assumes the host holds addr/data/format/cs steady for at least STAGES+1
// cycles after wr_n rises, so the bus and the strobe edge stay aligned.
module qdac_bus_sync #(
    parameter int DW     = 14,
    parameter int AW     = 3,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_i,
    input  logic          wr_n_i,
    input  logic          ldac_n_i,
    input  logic          fmt_i,
    input  logic          hi_sel_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          cs_n_o,
    output logic          ldac_n_o,
    output logic          fmt_o,
    output logic          hi_sel_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          wr_rise_o
);
    localparam int BW = 5 + AW + DW;
    localparam logic [BW-1:0] IDLE = {3'b111, {(BW-3){1'b0}}};

    logic [BW-1:0] pipe [STAGES];
    logic [BW-1:0] bus_in;
    logic          wr_now;
    logic          wr_last;

    assign bus_in = {cs_n_i, wr_n_i, ldac_n_i, fmt_i, hi_sel_i, addr_i, data_i};

    // First synchroniser stage samples the raw bus.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= IDLE;
        else        pipe[0] <= bus_in;
    end

    // Remaining stages shift the sample along.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[s] <= IDLE;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign {cs_n_o, wr_now, ldac_n_o, fmt_o, hi_sel_o, addr_o, data_o} = pipe[STAGES-1];

    // Remembers the previous synchronised strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_last <= 1'b1;
        else        wr_last <= wr_now;
    end

    assign wr_rise_o = wr_now & ~wr_last;
endmodule

// File: rtl/qdac_wr_decode.sv
// Turns a synchronised write edge into per-channel low/high field enables
// and steers the bus bits onto the two field data paths.
// Assumes inputs are already in the clock domain; addresses >= NCH are dropped.
module qdac_wr_decode
    import qdac_pkg::*;
#(
    parameter int DW    = 14,
    parameter int AW    = 3,
    parameter int NCH   = 4,
    parameter int LOW_W = 8
) (
    input  logic              wr_rise,
    input  logic              cs_n,
    input  logic              fmt,
    input  logic              hi_sel,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     data,
    output logic              wr_fire,
    output logic [NCH-1:0]    lo_en,
    output logic [NCH-1:0]    hi_en,
    output logic [LOW_W-1:0]  lo_data,
    output logic [DW-LOW_W-1:0] hi_data
);
    localparam int HI_W = DW - LOW_W;

    load_fmt_e fmt_e;
    logic      take_lo;
    logic      take_hi;

    assign fmt_e   = load_fmt_e'(fmt);
    assign wr_fire = wr_rise & ~cs_n;

    // Chooses which field(s) a committed write touches.
    always_comb begin
        take_lo = 1'b1;
        take_hi = 1'b1;
        if (fmt_e == FMT_BYTES) begin
            take_lo = ~hi_sel;
            take_hi = hi_sel;
        end
    end

    // Word format takes the upper bits in place; byte format takes them right-justified.
    always_comb begin
        lo_data = data[LOW_W-1:0];
        if (fmt_e == FMT_WORD) hi_data = data[DW-1:LOW_W];
        else                   hi_data = data[HI_W-1:0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        logic hit;
        assign hit      = wr_fire && (addr == AW'(c));
        assign lo_en[c] = hit & take_lo;
        assign hi_en[c] = hit & take_hi;
    end
endmodule

// File: rtl/qdac_channel.sv
// One double-buffered channel: an input register written in fields and a
// DAC latch loaded from it while the synchronised load control is low.
// Assumes clr_n is an asynchronous level; rst_n is synchronous.
module qdac_channel #(
    parameter int DW    = 14,
    parameter int LOW_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_n,
    input  logic                lo_en,
    input  logic                hi_en,
    input  logic [LOW_W-1:0]    lo_data,
    input  logic [DW-LOW_W-1:0] hi_data,
    input  logic                load_en,
    output logic [DW-1:0]       in_q,
    output logic [DW-1:0]       lat_q
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    logic [DW-1:0] in_next;

    // Merges the enabled fields of a write into the held value.
    always_comb begin
        in_next = in_q;
        if (lo_en) in_next[LOW_W-1:0] = lo_data;
        if (hi_en) in_next[DW-1:LOW_W] = hi_data;
    end

    // Holds the input register and the latch; clear wins asynchronously.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            in_q  <= MID;
            lat_q <= MID;
        end else if (!rst_n) begin
            in_q  <= MID;
            lat_q <= MID;
        end else begin
            in_q <= in_next;
            if (load_en) lat_q <= in_next;
        end
    end
endmodule

// File: rtl/quad_dac_load_if.sv
// Top of the four-channel DAC host load interface: synchroniser, write
// decoder and NCH double-buffered channels. Outputs are the latch codes.
// Assumes the host bus timing described in qdac_bus_sync.
module quad_dac_load_if
    import qdac_pkg::*;
#(
    parameter int DW     = DAC_W,
    parameter int NCH    = NUM_CH,
    parameter int AW     = ADDR_W,
    parameter int LW     = LOW_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [AW-1:0]     addr,
    input  logic              byte_fmt,
    input  logic              byte_hi,
    input  logic [DW-1:0]     data,
    input  logic              ldac_n,
    output logic [NCH*DW-1:0] dac_out
);
    localparam int HW = DW - LW;

    logic              cs_s, ldac_s, fmt_s, hi_s, wr_rise, wr_fire;
    logic [AW-1:0]     addr_s;
    logic [DW-1:0]     data_s;
    logic [NCH-1:0]    lo_en, hi_en;
    logic [LW-1:0]     lo_data;
    logic [HW-1:0]     hi_data;
    logic [NCH*DW-1:0] in_regs;

    qdac_bus_sync #(.DW(DW), .AW(AW), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cs_n),
        .wr_n_i   (wr_n),
        .ldac_n_i (ldac_n),
        .fmt_i    (byte_fmt),
        .hi_sel_i (byte_hi),
        .addr_i   (addr),
        .data_i   (data),
        .cs_n_o   (cs_s),
        .ldac_n_o (ldac_s),
        .fmt_o    (fmt_s),
        .hi_sel_o (hi_s),
        .addr_o   (addr_s),
        .data_o   (data_s),
        .wr_rise_o(wr_rise)
    );

    qdac_wr_decode #(.DW(DW), .AW(AW), .NCH(NCH), .LOW_W(LW)) u_dec (
        .wr_rise (wr_rise),
        .cs_n    (cs_s),
        .fmt     (fmt_s),
        .hi_sel  (hi_s),
        .addr    (addr_s),
        .data    (data_s),
        .wr_fire (wr_fire),
        .lo_en   (lo_en),
        .hi_en   (hi_en),
        .lo_data (lo_data),
        .hi_data (hi_data)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        qdac_channel #(.DW(DW), .LOW_W(LW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_n   (clr_n),
            .lo_en   (lo_en[c]),
            .hi_en   (hi_en[c]),
            .lo_data (lo_data),
            .hi_data (hi_data),
            .load_en (~ldac_s),
            .in_q    (in_regs[c*DW +: DW]),
            .lat_q   (dac_out[c*DW +: DW])
        );
    end
endmodule

// File: rtl/qdac_checker.sv
// Property checker for quad_dac_load_if, attached by bind below.
// Assumes clr_n levels last at least one clock period.
module qdac_checker #(
    parameter int DW  = 14,
    parameter int NCH = 4,
    parameter int AW  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              ldac_sync,
    input logic              wr_fire,
    input logic [AW-1:0]     addr_s,
    input logic [NCH*DW-1:0] in_regs,
    input logic [NCH*DW-1:0] dac_out
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);
    localparam logic [NCH*DW-1:0] ALL_MID = {NCH{MID}};

    // R1: reset gives mid-scale on every channel
    a_r1_reset_mid: assert property (@(posedge clk) disable iff (!clr_n)
        !rst_n |=> (dac_out == ALL_MID));

    // R10: clear level holds every output at mid-scale
    a_r10_clear_mid: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_out == ALL_MID));

    // R5: out-of-range address leaves input registers untouched
    a_r5_bad_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && (addr_s >= AW'(NCH)) && clr_n) |=> ($stable(in_regs) || !clr_n));

    // R8: load control high freezes the outputs
    a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_sync && clr_n) |=> ($stable(dac_out) || !clr_n));

    // R9: load control low makes the latches match the input registers
    a_r9_latch_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldac_sync && clr_n) |=> (dac_out == in_regs));
endmodule

bind quad_dac_load_if qdac_checker #(.DW(DW), .NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .ldac_sync (ldac_s),
    .wr_fire   (wr_fire),
    .addr_s    (addr_s),
    .in_regs   (in_regs),
    .dac_out   (dac_out)
);

// File: tb/tb_quad_dac_load_if.sv
// Scoreboard bench: driver tasks update a reference model and queue the
// expected outputs; a monitor process pops and compares them.
module tb_quad_dac_load_if;
    localparam int DW  = 14;
    localparam int NCH = 4;
    localparam logic [DW-1:0] MID = 14'h2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0, clr_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic byte_fmt = 1'b0, byte_hi = 1'b0, ldac_n = 1'b0;
    logic [DW-1:0] data = '0;
    logic [NCH*DW-1:0] dac_out;

    int checks = 0, errors = 0;

    typedef struct {
        string             tag;
        logic [NCH*DW-1:0] exp;
    } item_t;
    item_t sb_q[$];

    logic [DW-1:0] m_in  [NCH];
    logic [DW-1:0] m_lat [NCH];
    logic          m_ldac_hi = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    quad_dac_load_if dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
        .addr(addr), .byte_fmt(byte_fmt), .byte_hi(byte_hi), .data(data),
        .ldac_n(ldac_n), .dac_out(dac_out)
    );

    function automatic logic [NCH*DW-1:0] model_out();
        logic [NCH*DW-1:0] v;
        for (int k = 0; k < NCH; k++) v[k*DW +: DW] = m_lat[k];
        return v;
    endfunction

    task automatic compare(string tag, logic [NCH*DW-1:0] exp);
        checks++;
        if (dac_out !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, dac_out, exp);
        end
    endtask

    // Driver side: queue the model's outputs and wait for the monitor.
    task automatic expect_out(string tag);
        item_t it;
        it.tag = tag;
        it.exp = model_out();
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    // Monitor: lets the pipeline settle, then compares at a falling edge.
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            repeat (4) @(negedge clk);
            compare(sb_q[0].tag, sb_q[0].exp);
            void'(sb_q.pop_front());
        end
    end

    task automatic model_all_mid();
        for (int k = 0; k < NCH; k++) begin
            m_in[k]  = MID;
            m_lat[k] = MID;
        end
    endtask

    task automatic wr_begin(input logic [2:0] a, input logic [DW-1:0] d,
                            input logic fmt, input logic hi, input logic sel);
        @(negedge clk);
        cs_n = ~sel; addr = a; data = d; byte_fmt = fmt; byte_hi = hi;
        wr_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_end(input logic [2:0] a, input logic [DW-1:0] d,
                          input logic fmt, input logic hi, input logic sel);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        if (sel && a < 3'(NCH)) begin
            if (!fmt) m_in[a] = d;
            else if (!hi) m_in[a][7:0] = d[7:0];
            else m_in[a][13:8] = d[5:0];
            if (!m_ldac_hi) m_lat[a] = m_in[a];
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [DW-1:0] d,
                              input logic fmt, input logic hi, input logic sel);
        wr_begin(a, d, fmt, hi, sel);
        wr_end(a, d, fmt, hi, sel);
    endtask

    task automatic set_ldac(input logic level);
        @(negedge clk);
        ldac_n = level;
        m_ldac_hi = level;
        if (!level) for (int k = 0; k < NCH; k++) m_lat[k] = m_in[k];
    endtask

    initial begin
        model_all_mid();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_out("R1 reset mid-scale");

        // R2: word writes
        host_write(3'd0, 14'h1234, 1'b0, 1'b0, 1'b1);
        host_write(3'd3, 14'h3FFF, 1'b0, 1'b0, 1'b1);
        expect_out("R2 word writes ch0 ch3");
        host_write(3'd2, 14'h0001, 1'b0, 1'b0, 1'b1);
        expect_out("R2 word write ch2");

        // R3 / R4: byte format with junk in unused bus bits
        host_write(3'd1, 14'h3EA5, 1'b1, 1'b0, 1'b1);
        expect_out("R3 low byte ch1");
        host_write(3'd1, 14'h3FD5, 1'b1, 1'b1, 1'b1);
        expect_out("R4 high byte ch1");

        // R5: out-of-range addresses
        for (int a = 4; a < 8; a++) host_write(3'(a), 14'h0F0F, 1'b0, 1'b0, 1'b1);
        expect_out("R5 addr 4-7 ignored");

        // R6: chip select inactive
        host_write(3'd2, 14'h2AAA, 1'b0, 1'b0, 1'b0);
        expect_out("R6 cs_n high ignored");

        // R7: nothing until the strobe rises, late bus change ignored
        wr_begin(3'd2, 14'h0777, 1'b0, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        compare("R7 wr_n held low", model_out());
        wr_end(3'd2, 14'h0777, 1'b0, 1'b0, 1'b1);
        data = 14'h1111; addr = 3'd0;
        expect_out("R7 commit on rise, late change ignored");

        // R8 / R9: frozen outputs, then a simultaneous update
        set_ldac(1'b1);
        host_write(3'd0, 14'h0100, 1'b0, 1'b0, 1'b1);
        host_write(3'd1, 14'h0200, 1'b0, 1'b0, 1'b1);
        host_write(3'd2, 14'h0300, 1'b0, 1'b0, 1'b1);
        host_write(3'd3, 14'h0400, 1'b0, 1'b0, 1'b1);
        expect_out("R8 outputs held with ldac_n high");
        set_ldac(1'b0);
        expect_out("R9 falling ldac_n loads all");

        // R10: asynchronous clear, observed before any rising edge
        @(negedge clk);
        clr_n = 1'b0;
        model_all_mid();
        #5;
        compare("R10 async clear mid-cycle", model_out());
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        expect_out("R10 clear held");

        // R10: clear also empties the input registers
        set_ldac(1'b1);
        host_write(3'd0, 14'h0ABC, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        clr_n = 1'b0;
        model_all_mid();
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        set_ldac(1'b0);
        expect_out("R10 input registers cleared");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule